// File: doc/BRIEF.md
# Sleep-Mode Interrupt Capture and Replay

This block sits between a bank of external interrupt lines and a parent interrupt controller. It keeps a recorded-status bit per line that is set whenever the line shows its configured event, and it keeps recording even while the block is disabled or the line is masked. When software issues a flush command, every recorded line that is not masked is sent to the parent controller again as a single-cycle pulse on its own replay output. The recorded status of each replayed line is cleared at the same moment.

Each line has three configuration bits: mask, sensitivity (level or edge) and polarity (high/rising or low/falling). Each bit can only be changed through a pair of write-one-to-set and write-one-to-clear addresses. The recorded status is cleared per line through a write-one-to-clear acknowledge address. A control word holds an enable bit, an edge-only recording mode bit and a self-clearing flush bit. Software reaches all of this through a plain 32-bit register bus. Reads are combinational, and writes take effect at the clock edge where the write strobe is sampled. The external inputs are asynchronous and pass through a two-flop synchronizer before any event is detected.

Top module: `sleep_irq_replay`

## Requirements
- R1: After reset the mask of every line reads 1 (masked). Sensitivity, polarity, recorded status and control all read 0, and replay_o is low.
- R2: Byte offsets are: status/acknowledge 0x40, mask set 0xC0, mask clear 0x100, sensitivity set 0x180, sensitivity clear 0x1C0, polarity set 0x240, polarity clear 0x280, control 0x300. Line n is bit (n mod 32) of the word at offset + 4*floor(n/32). A write to a word that holds no line changes nothing.
- R3: Writing a word to a set (or clear) address sets (or clears) exactly the configuration bits written as 1, and leaves the others unchanged. Reading either address of a pair returns the current state of that configuration bank.
- R4: Writing 1 to a bit at the acknowledge offset clears that line's recorded status, and 0 bits leave status unchanged. Reading the acknowledge offset returns the recorded status. If a new event arrives in the same cycle as the clear, the new event wins.
- R5: Sensitivity 0 selects edge recording: polarity 1 records rising edges and polarity 0 records falling edges. Sensitivity 1 selects level recording: status is set in every cycle in which the synchronized line equals its polarity. Events are recorded whatever the enable and mask bits are, and a change on an input is recorded within three clock edges.
- R6: With control bit 1 (edge-only) set, a line configured for level sensitivity records only the edge into its active level, and holding that level does not set the status again.
- R7: A control write with bits 2 (flush) and 0 (enable) both set makes bit 2 read 1 for one cycle. At the following clock edge, replay_o pulses for exactly one cycle on every unmasked line whose status is set, and those status bits clear.
- R8: A masked line is not replayed by a flush and its recorded status is kept. After the line is unmasked, a later flush replays it.
- R9: A control write with bit 2 set but bit 0 clear does nothing as a flush: bit 2 reads 0, replay_o stays low and status is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 12 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, sampled at the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_i | input | N_LINES | Asynchronous external interrupt lines |
| replay_o | output | N_LINES | Single-cycle replay pulses toward the parent controller |

## Verification
The bench sweeps every line through all four sensitivity/polarity codes, both with and without edge-only mode. For each case it drives the inactive level, then the active level, then an acknowledge while the level is held, then a return to inactive. This separates level recording from edge recording, rising from falling, and edge-only from plain level mode, and it shows that recording continues while the block is disabled and the line is masked. Flush is tried with several event patterns against several masks, which separates replay of unmasked lines from the status kept for masked ones. A flush written without enable is also tried. Configuration banks are driven with mixed set and clear patterns and read back through both addresses of each pair.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STAT_ACK = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 12'h0C0;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_SENS_SET = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_SENS_CLR = 12'h1C0;
  localparam logic [ADDR_W-1:0] OFS_POL_SET  = 12'h240;
  localparam logic [ADDR_W-1:0] OFS_POL_CLR  = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h300;

  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_EDGE  = 1;
  localparam int unsigned CTL_FLUSH = 2;

  // Address of the word holding a given bank index of a register group
  function automatic logic [ADDR_W-1:0] bank_addr(logic [ADDR_W-1:0] base, int bank);
    return base + ADDR_W'(4 * bank);
  endfunction
endpackage

// File: rtl/sic_in_sync.sv
module sic_in_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stg1_q, stg2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      prev_q <= '0;
    end else begin
      stg1_q <= raw_i;
      stg2_q <= stg1_q;
      prev_q <= stg2_q;
    end
  end

  assign lvl_o  = stg2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/sic_cfg_bank.sv
module sic_cfg_bank #(
  parameter int unsigned N       = 8,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);
  logic [N-1:0] state_q, state_n;
  logic         upd_en;

  assign upd_en = |(set_i | clr_i);

  always_comb begin
    state_n = (state_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= {N{RST_VAL}};
    end else if (upd_en) begin
      state_q <= state_n;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sic_event_gen.sv
module sic_event_gen #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] sens_i,
  input  logic [N-1:0] pol_i,
  input  logic         edge_only_i,
  output logic [N-1:0] event_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic active_now, active_before, level_mode;
    assign active_now    = (lvl_i[g]  == pol_i[g]);
    assign active_before = (prev_i[g] == pol_i[g]);
    assign level_mode    = sens_i[g] & ~edge_only_i;
    assign event_o[g]    = level_mode ? active_now : (active_now & ~active_before);
  end
endmodule

// File: rtl/sic_status.sv
module sic_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] mask_i,
  input  logic         flush_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] replay_o
);
  logic [N-1:0] status_q, status_n;
  logic [N-1:0] replay_q, replay_n;

  always_comb begin
    replay_n = flush_i ? (status_q & ~mask_i) : '0;
    status_n = (status_q & ~ack_i & ~replay_n) | event_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      replay_q <= '0;
    end else begin
      status_q <= status_n;
      replay_q <= replay_n;
    end
  end

  assign status_o = status_q;
  assign replay_o = replay_q;
endmodule

// File: rtl/sleep_irq_replay.sv
module sleep_irq_replay
  import sic_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [N_LINES-1:0]   irq_i,
  output logic [N_LINES-1:0]   replay_o
);
  localparam int unsigned N_BANKS = (N_LINES + DATA_W - 1) / DATA_W;

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  // Per-line write strobes decoded from the bus
  logic [N_LINES-1:0] ack_bits;
  logic [N_LINES-1:0] mask_set, mask_clr, sens_set, sens_clr, pol_set, pol_clr;

  for (genvar g = 0; g < N_LINES; g++) begin : g_dec
    localparam int BK = g / DATA_W;
    localparam int BT = g % DATA_W;
    logic bit_one;
    assign bit_one     = wr_i & wdata_i[BT];
    assign ack_bits[g] = bit_one & (addr_i == bank_addr(OFS_STAT_ACK, BK));
    assign mask_set[g] = bit_one & (addr_i == bank_addr(OFS_MASK_SET, BK));
    assign mask_clr[g] = bit_one & (addr_i == bank_addr(OFS_MASK_CLR, BK));
    assign sens_set[g] = bit_one & (addr_i == bank_addr(OFS_SENS_SET, BK));
    assign sens_clr[g] = bit_one & (addr_i == bank_addr(OFS_SENS_CLR, BK));
    assign pol_set[g]  = bit_one & (addr_i == bank_addr(OFS_POL_SET,  BK));
    assign pol_clr[g]  = bit_one & (addr_i == bank_addr(OFS_POL_CLR,  BK));
  end

  // Configuration banks
  logic [N_LINES-1:0] mask_q, sens_q, pol_q;

  sic_cfg_bank #(.N(N_LINES), .RST_VAL(1'b1)) mask_bank_i (
    .clk(clk_i), .rst_n(rst_sync_n), .set_i(mask_set), .clr_i(mask_clr), .state_o(mask_q));
  sic_cfg_bank #(.N(N_LINES), .RST_VAL(1'b0)) sens_bank_i (
    .clk(clk_i), .rst_n(rst_sync_n), .set_i(sens_set), .clr_i(sens_clr), .state_o(sens_q));
  sic_cfg_bank #(.N(N_LINES), .RST_VAL(1'b0)) pol_bank_i (
    .clk(clk_i), .rst_n(rst_sync_n), .set_i(pol_set), .clr_i(pol_clr), .state_o(pol_q));

  // Control word
  logic ctl_wr;
  logic en_q, en_n, edge_q, edge_n, flush_q, flush_n;

  assign ctl_wr = wr_i & (addr_i == OFS_CTRL);

  always_comb begin
    en_n    = en_q;
    edge_n  = edge_q;
    flush_n = 1'b0;
    if (ctl_wr) begin
      en_n    = wdata_i[CTL_EN];
      edge_n  = wdata_i[CTL_EDGE];
      flush_n = wdata_i[CTL_FLUSH] & wdata_i[CTL_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q   <= en_n;
        edge_q <= edge_n;
      end
      flush_q <= flush_n;
    end
  end

  // Input path and event detection
  logic [N_LINES-1:0] lvl_s, prev_s, event_s;

  sic_in_sync #(.N(N_LINES)) sync_i (
    .clk(clk_i), .rst_n(rst_sync_n), .raw_i(irq_i), .lvl_o(lvl_s), .prev_o(prev_s));

  sic_event_gen #(.N(N_LINES)) evgen_i (
    .lvl_i(lvl_s), .prev_i(prev_s), .sens_i(sens_q), .pol_i(pol_q),
    .edge_only_i(edge_q), .event_o(event_s));

  // Recorded status and replay
  logic [N_LINES-1:0] status_q;
  logic               flush_go;

  assign flush_go = flush_q & en_q;

  sic_status #(.N(N_LINES)) status_i (
    .clk(clk_i), .rst_n(rst_sync_n), .event_i(event_s), .ack_i(ack_bits),
    .mask_i(mask_q), .flush_i(flush_go), .status_o(status_q), .replay_o(replay_o));

  // Read mux
  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < int'(N_LINES); n++) begin
      if (addr_i == bank_addr(OFS_STAT_ACK, n / DATA_W)) rdata_o[n % DATA_W] = status_q[n];
      if (addr_i == bank_addr(OFS_MASK_SET, n / DATA_W) ||
          addr_i == bank_addr(OFS_MASK_CLR, n / DATA_W)) rdata_o[n % DATA_W] = mask_q[n];
      if (addr_i == bank_addr(OFS_SENS_SET, n / DATA_W) ||
          addr_i == bank_addr(OFS_SENS_CLR, n / DATA_W)) rdata_o[n % DATA_W] = sens_q[n];
      if (addr_i == bank_addr(OFS_POL_SET, n / DATA_W) ||
          addr_i == bank_addr(OFS_POL_CLR, n / DATA_W))  rdata_o[n % DATA_W] = pol_q[n];
    end
    if (addr_i == OFS_CTRL) begin
      rdata_o[CTL_EN]    = en_q;
      rdata_o[CTL_EDGE]  = edge_q;
      rdata_o[CTL_FLUSH] = flush_q;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{N_BANKS};
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] status_q,
  input logic [N-1:0] replay_o,
  input logic [N-1:0] ack_bits,
  input logic [N-1:0] event_s,
  input logic [N-1:0] mask_set,
  input logic [N-1:0] mask_clr,
  input logic         flush_q,
  input logic         en_q
);
  AST_REPLAY_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_o) |-> $past(flush_q && en_q)); // R7

  AST_REPLAY_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_o & ~$past(status_q)) == '0); // R7

  AST_NO_REPLAY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_o & $past(mask_q)) == '0); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & $past(ack_bits & ~event_s)) == '0); // R4

  AST_EVENT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (~status_q & $past(event_s)) == '0); // R5

  AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q ^ $past(mask_q)) & ~$past(mask_set | mask_clr)) == '0); // R3
endmodule

bind sleep_irq_replay sic_checker #(.N(N_LINES)) chk_i (
  .clk(clk_i), .rst_n(rst_sync_n), .mask_q(mask_q), .status_q(status_q),
  .replay_o(replay_o), .ack_bits(ack_bits), .event_s(event_s),
  .mask_set(mask_set), .mask_clr(mask_clr), .flush_q(flush_q), .en_q(en_q));

// File: tb/sleep_irq_replay_tb.sv
module sleep_irq_replay_tb_top;
  localparam int N = 8;
  localparam logic [11:0] A_ACK = 12'h040, A_MS = 12'h0C0, A_MC = 12'h100,
                          A_SS = 12'h180, A_SC = 12'h1C0, A_PS = 12'h240,
                          A_PC = 12'h280, A_CTL = 12'h300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq_drv = '0;
  logic [N-1:0] replay;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sleep_irq_replay #(.N_LINES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq_drv), .replay_o(replay));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  mdl;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(A_MS, rd);  check("R1 mask set", rd, 32'hFF);
    bus_read(A_MC, rd);  check("R1 mask clr", rd, 32'hFF);
    bus_read(A_SS, rd);  check("R1 sens", rd, 0);
    bus_read(A_PC, rd);  check("R1 pol", rd, 0);
    bus_read(A_CTL, rd); check("R1 ctrl", rd, 0);
    bus_read(A_ACK, rd); check("R1 status", rd, 0);
    check("R1 replay", {24'h0, replay}, 0);

    // R2 write to a word with no lines changes nothing
    bus_write(A_MC + 12'h4, 32'hFFFF_FFFF);
    bus_read(A_MS, rd); check("R2 empty bank", rd, 32'hFF);

    // R3 set/clear banks with mixed patterns
    for (int b = 0; b < 3; b++) begin
      logic [11:0] sa, ca;
      sa = (b == 0) ? A_MS : (b == 1) ? A_SS : A_PS;
      ca = (b == 0) ? A_MC : (b == 1) ? A_SC : A_PC;
      mdl = (b == 0) ? 8'hFF : 8'h00;
      for (int k = 0; k < 8; k++) begin
        logic [7:0] pat;
        pat = 8'((k * 37 + 11 + b * 5) & 255);
        if (k == 3) pat = 8'h00;
        if (k % 2 == 0) begin bus_write(sa, {24'h0, pat}); mdl = mdl | pat; end
        else            begin bus_write(ca, {24'h0, pat}); mdl = mdl & ~pat; end
        bus_read(sa, rd); check("R3 via set addr", rd, {24'h0, mdl});
        bus_read(ca, rd); check("R3 via clr addr", rd, {24'h0, mdl});
      end
    end
    bus_write(A_MS, 32'hFF);

    // R4 R5 R6: every line, every sens/pol code, with and without edge-only
    for (int c = 0; c < 4; c++) begin
      for (int eo = 0; eo < 2; eo++) begin
        logic sens, pol, lvl_mode;
        sens = c[1]; pol = c[0];
        lvl_mode = sens && (eo == 0);
        bus_write(sens ? A_SS : A_SC, 32'hFF);
        bus_write(pol ? A_PS : A_PC, 32'hFF);
        bus_write(A_CTL, (eo != 0) ? 32'h2 : 32'h0);
        for (int n = 0; n < N; n++) begin
          irq_drv = pol ? 8'h00 : 8'hFF;
          idle(5);
          bus_write(A_ACK, 32'hFF);
          idle(2);
          bus_read(A_ACK, rd); check("R5 idle no event", rd, 0);
          irq_drv[n] = pol;
          idle(5);
          bus_read(A_ACK, rd);
          check((sens && eo != 0) ? "R6 edge-only assert" : "R5 assert", rd, 32'h1 << n);
          bus_write(A_ACK, 32'h1 << n);
          idle(2);
          bus_read(A_ACK, rd);
          check(lvl_mode ? "R4 ack under level" : "R6 R4 ack after edge", rd,
                lvl_mode ? (32'h1 << n) : 0);
          irq_drv[n] = ~pol;
          idle(5);
          bus_read(A_ACK, rd);
          check("R5 deassert", rd, lvl_mode ? (32'h1 << n) : 0);
        end
      end
    end

    // R7 R8 R9: flush with patterns and masks (rising-edge lines)
    bus_write(A_SC, 32'hFF);
    bus_write(A_PS, 32'hFF);
    irq_drv = '0;
    idle(5);
    bus_write(A_ACK, 32'hFF);
    for (int pi = 0; pi < 4; pi++) begin
      for (int mi = 0; mi < 3; mi++) begin
        logic [7:0] p, m;
        p = (pi == 0) ? 8'h01 : (pi == 1) ? 8'h80 : (pi == 2) ? 8'hA5 : 8'hFF;
        m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h0F : 8'hFF;
        bus_write(A_MS, {24'h0, m});
        bus_write(A_MC, {24'h0, ~m});
        irq_drv = p; idle(5); irq_drv = '0; idle(5);
        bus_read(A_ACK, rd); check("R5 recorded pattern", rd, {24'h0, p});
        bus_write(A_CTL, 32'h5);
        bus_read(A_CTL, rd); check("R7 flush bit visible", rd, 32'h5);
        check("R7 no early replay", {24'h0, replay}, 0);
        @(negedge clk);
        check("R8 R7 replay pulse", {24'h0, replay}, {24'h0, p & ~m});
        @(negedge clk);
        check("R7 one-cycle pulse", {24'h0, replay}, 0);
        bus_read(A_CTL, rd); check("R7 flush self-clear", rd, 32'h1);
        bus_read(A_ACK, rd); check("R8 masked kept", rd, {24'h0, p & m});
        bus_write(A_MC, 32'hFF);
        bus_write(A_CTL, 32'h5);
        @(negedge clk);
        check("R8 replay after unmask", {24'h0, replay}, {24'h0, p & m});
        @(negedge clk);
        bus_read(A_ACK, rd); check("R7 status cleared", rd, 0);
        // R9 flush without enable
        irq_drv = p; idle(5); irq_drv = '0; idle(5);
        bus_write(A_CTL, 32'h4);
        bus_read(A_CTL, rd); check("R9 ctrl reads 0", rd, 0);
        for (int w = 0; w < 3; w++) begin
          check("R9 no replay", {24'h0, replay}, 0);
          @(negedge clk);
        end
        bus_read(A_ACK, rd); check("R9 status kept", rd, {24'h0, p});
        bus_write(A_ACK, 32'hFF);
      end
    end

    finish_run();
  end
endmodule